// File: doc/BRIEF.md
# Multi-Phase Reset Sequencer

This block sequences the reset of a chip through three ordered phases after a power-on reset, an external reset request or one of several functional reset events. While it is busy it holds the reset outputs of the power domains, the flash and the external reset pin. After the last phase it returns to an idle state.

Each functional event can be disabled for the rest of a power-on period. Each event can also be set to run a short sequence that enters Phase3 directly and leaves the domains and the flash untouched. A third setting lets an event drive the external reset pin. Each enabled event sets a status flag, and software clears these flags by writing a one to them.

A standby request reuses Phase1. All domains except domain 0 stay in reset, and the external pin stays free so that it can act as a wakeup. On wakeup the device may be told to leave the flash powered down and held in reset.

Top module: `rst_sequencer`

## Requirements
- R1: Each enabled functional event sets its bit in the status register, and several bits may be set in one cycle. The status register is at register address 0. Writing a 1 to a bit clears that bit, unless an event sets it in the same cycle.
- R2: The disable register is at address 1 and takes only the first write after power-on reset. Later writes are ignored, and a read returns the first value written.
- R3: An event whose disable bit is 1 is ignored: it sets no status bit and `phase` stays where it is.
- R4: `phase` is 1 in the cycle after the sampling edge of any of the following, in any phase:
  - an external request;
  - an enabled event whose short-sequence bit is 0.
  The phase encoding is 0 idle, 1 Phase1, 2 Phase2 and 3 Phase3.
- R5: Phase1 lasts `P1_MIN` cycles and then moves to Phase2. Phase2 moves to Phase3 on `flash_done`. Phase3 returns to idle on `flash_done`.
- R6: The short-sequence register is at address 2. An enabled event whose short-sequence bit is 1 moves the sequencer from idle, or from Phase3, to the start of Phase3. During this, `dom_rst` and `flash_rst` stay low.
- R7: The pin-drive register is at address 3. `ext_rst_out` rises after an external request, or after an enabled event whose pin-drive bit is 1. It stays high until Phase3 ends.
- R8: `stby_enter` is honoured only in idle and moves the sequencer to Phase1. The Phase1 counter is then frozen until `stby_exit`. While the counter is frozen:
  - `dom_rst[0]` is low;
  - every other domain reset is high;
  - `ext_rst_out` is low.
- R9: If `flash_keep_off` is high at standby entry, Phase2 and Phase3 each last one cycle without waiting for `flash_done`. `flash_rst` then stays high, in idle as well, until the next sequence that starts in Phase1.
- R10: While `por_n` is low, `phase` is 1 and every reset output is high. Power-on reset also clears the status, disable, short-sequence and pin-drive registers and the write-once lock.
- R11: `dom_rst` bits are high only in Phase1 and Phase2. Domain 0 is the exception: it stays low during a sequence that began with standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_req | input | 1 | External reset request |
| fevt | input | NEV | Functional reset events |
| stby_enter | input | 1 | Standby entry request |
| stby_exit | input | 1 | Standby wakeup |
| flash_keep_off | input | 1 | Keep flash off after standby |
| flash_done | input | 1 | Flash initialisation complete |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | NEV | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | NEV | Register read data |
| phase | output | 2 | Current phase |
| dom_rst | output | NDOM | Power-domain resets |
| flash_rst | output | 1 | Flash reset |
| ext_rst_out | output | 1 | External reset pin drive |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the disable register does not change once it is locked;
- enabled events reach the status register;
- an external request always lands in Phase1;
- Phase2 holds while it waits for the flash;
- the output pattern during standby;
- the flash reset while the flash is held off.

Some behaviours only the bench scenarios can show:
- the exact length of Phase1, before and after standby;
- the order of phases in a short sequence;
- the pin staying asserted to the end of Phase3;
- the lock being cleared by a second power-on reset.

The bench's reference model compares every output on every cycle.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int NEV    = 4,
  parameter int NDOM   = 3,
  parameter int P1_MIN = 16
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            ext_req,
  input  logic [NEV-1:0]  fevt,
  input  logic            stby_enter,
  input  logic            stby_exit,
  input  logic            flash_keep_off,
  input  logic            flash_done,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [NEV-1:0]  wr_data,
  input  logic [1:0]      rd_addr,
  output logic [NEV-1:0]  rd_data,
  output logic [1:0]      phase,
  output logic [NDOM-1:0] dom_rst,
  output logic            flash_rst,
  output logic            ext_rst_out
);
  localparam int CW = $clog2(P1_MIN) + 1;

  typedef enum logic [1:0] {IDLE = 2'd0, PH1 = 2'd1, PH2 = 2'd2, PH3 = 2'd3} ph_t;

  ph_t            st;
  logic [CW-1:0]  cnt;
  logic           stby, lp_seq, flash_off, ext_flag, lock;
  logic [NEV-1:0] fes, dis, ss, pin;

  wire [NEV-1:0] live    = fevt & ~dis;
  wire           go_long = ext_req | (|(live & ~ss));
  wire           go_shrt = |(live & ss);
  wire           drive   = ext_req | (|(live & pin));
  wire           done_ok = flash_done | flash_off;
  wire           p1_end  = !stby && (cnt == CW'(P1_MIN - 1));
  wire           in_rst  = (st == PH1) || (st == PH2);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= PH1;
      cnt       <= '0;
      stby      <= 1'b0;
      lp_seq    <= 1'b0;
      flash_off <= 1'b0;
      ext_flag  <= 1'b1;
    end else if (go_long) begin
      st        <= PH1;
      cnt       <= '0;
      stby      <= 1'b0;
      lp_seq    <= 1'b0;
      flash_off <= 1'b0;
      ext_flag  <= 1'b1 & (ext_flag | drive);
    end else begin
      ext_flag <= ext_flag | drive;
      case (st)
        IDLE:
          if (go_shrt) st <= PH3;
          else if (stby_enter) begin
            st        <= PH1;
            stby      <= 1'b1;
            lp_seq    <= 1'b1;
            flash_off <= flash_keep_off;
            cnt       <= '0;
          end
        PH1:
          if (stby) begin
            if (stby_exit) stby <= 1'b0;
          end else if (p1_end) begin
            st  <= PH2;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        PH2:
          if (done_ok) st <= PH3;
        PH3:
          if (!go_shrt && done_ok) begin
            st       <= IDLE;
            ext_flag <= 1'b0;
            lp_seq   <= 1'b0;
          end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fes  <= '0;
      dis  <= '0;
      ss   <= '0;
      pin  <= '0;
      lock <= 1'b0;
    end else begin
      fes <= (fes & ~((wr_en && wr_addr == 2'd0) ? wr_data : '0)) | live;
      if (wr_en && wr_addr == 2'd1 && !lock) begin
        dis  <= wr_data;
        lock <= 1'b1;
      end
      if (wr_en && wr_addr == 2'd2) ss  <= wr_data;
      if (wr_en && wr_addr == 2'd3) pin <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = fes;
      2'd1:    rd_data = dis;
      2'd2:    rd_data = ss;
      default: rd_data = pin;
    endcase
  end

  assign phase       = st;
  assign dom_rst     = {{(NDOM-1){in_rst}}, in_rst & ~lp_seq};
  assign flash_rst   = in_rst | flash_off;
  assign ext_rst_out = ext_flag & ~stby;
endmodule

module rst_sequencer_chk #(
  parameter int NEV  = 4,
  parameter int NDOM = 3
) (
  input logic            clk,
  input logic            por_n,
  input logic            ext_req,
  input logic [NEV-1:0]  fevt,
  input logic            stby_enter,
  input logic            flash_done,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic [1:0]      phase,
  input logic [NDOM-1:0] dom_rst,
  input logic            flash_rst,
  input logic            ext_rst_out,
  input logic            stby,
  input logic            lock,
  input logic [NEV-1:0]  dis,
  input logic [NEV-1:0]  fes,
  input logic            flash_off
);
  assert_flags_set_R1: assert property (@(posedge clk) disable iff (!por_n)
    ((fevt & ~dis) != '0) |=> ((fes & $past(fevt & ~dis)) == $past(fevt & ~dis)));

  assert_lock_holds_R2: assert property (@(posedge clk) disable iff (!por_n)
    (lock && wr_en && wr_addr == 2'd1) |=> $stable(dis));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!por_n)
    (phase == 2'd0 && !ext_req && (fevt & ~dis) == '0 && !stby_enter) |=> phase == 2'd0);

  assert_ext_to_p1_R4: assert property (@(posedge clk) disable iff (!por_n)
    ext_req |=> phase == 2'd1);

  assert_p2_waits_R5: assert property (@(posedge clk) disable iff (!por_n)
    (phase == 2'd2 && !flash_done && !flash_off && !ext_req && (fevt & ~dis) == '0)
      |=> phase == 2'd2);

  assert_standby_pins_R8: assert property (@(posedge clk) disable iff (!por_n)
    stby |-> (phase == 2'd1 && !dom_rst[0] && (&dom_rst[NDOM-1:1]) && !ext_rst_out));

  assert_flash_held_R9: assert property (@(posedge clk) disable iff (!por_n)
    flash_off |-> flash_rst);
endmodule

bind rst_sequencer rst_sequencer_chk #(.NEV(NEV), .NDOM(NDOM)) u_chk (
  .clk(clk), .por_n(por_n), .ext_req(ext_req), .fevt(fevt), .stby_enter(stby_enter),
  .flash_done(flash_done), .wr_en(wr_en), .wr_addr(wr_addr), .phase(phase),
  .dom_rst(dom_rst), .flash_rst(flash_rst), .ext_rst_out(ext_rst_out), .stby(stby),
  .lock(lock), .dis(dis), .fes(fes), .flash_off(flash_off)
);

// File: tb/rst_sequencer_tb.sv
module rst_sequencer_tb;
  localparam int NEV = 4, NDOM = 3, MIN = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_n = 1'b0, ext_req = 1'b0, stby_enter = 1'b0, stby_exit = 1'b0;
  logic flash_keep_off = 1'b0, flash_done = 1'b0, wr_en = 1'b0;
  logic [NEV-1:0] fevt = '0, wr_data = '0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [NEV-1:0] rd_data;
  logic [1:0] phase;
  logic [NDOM-1:0] dom_rst;
  logic flash_rst, ext_rst_out;

  rst_sequencer #(.NEV(NEV), .NDOM(NDOM), .P1_MIN(MIN)) u_dut (
    .clk(clk), .por_n(por_n), .ext_req(ext_req), .fevt(fevt), .stby_enter(stby_enter),
    .stby_exit(stby_exit), .flash_keep_off(flash_keep_off), .flash_done(flash_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .phase(phase), .dom_rst(dom_rst), .flash_rst(flash_rst),
    .ext_rst_out(ext_rst_out)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  int m_ph, m_cnt;
  bit m_stby, m_lp, m_foff, m_ext, m_lock;
  logic [NEV-1:0] m_fes, m_dis, m_ss, m_pin;

  task automatic mreset();
    m_ph = 1; m_cnt = 0; m_stby = 0; m_lp = 0; m_foff = 0; m_ext = 1; m_lock = 0;
    m_fes = '0; m_dis = '0; m_ss = '0; m_pin = '0;
  endtask

  task automatic mstep();
    logic [NEV-1:0] lv;
    bit lng, sht, drv, dok;
    lv  = fevt & ~m_dis;
    lng = ext_req || ((lv & ~m_ss) != 0);
    sht = (lv & m_ss) != 0;
    drv = ext_req || ((lv & m_pin) != 0);
    dok = flash_done || m_foff;
    if (wr_en && wr_addr == 2'd0) m_fes = m_fes & ~wr_data;
    m_fes = m_fes | lv;
    if (wr_en && wr_addr == 2'd1 && !m_lock) begin m_dis = wr_data; m_lock = 1; end
    if (wr_en && wr_addr == 2'd2) m_ss = wr_data;
    if (wr_en && wr_addr == 2'd3) m_pin = wr_data;
    if (drv) m_ext = 1;
    if (lng) begin
      m_ph = 1; m_cnt = 0; m_stby = 0; m_lp = 0; m_foff = 0;
    end else if (m_ph == 0) begin
      if (sht) m_ph = 3;
      else if (stby_enter) begin
        m_ph = 1; m_stby = 1; m_lp = 1; m_foff = flash_keep_off; m_cnt = 0;
      end
    end else if (m_ph == 1) begin
      if (m_stby) begin
        if (stby_exit) m_stby = 0;
      end else begin
        m_cnt++;
        if (m_cnt == MIN) begin m_ph = 2; m_cnt = 0; end
      end
    end else if (m_ph == 2) begin
      if (dok) m_ph = 3;
    end else if (!sht && dok) begin
      m_ph = 0; m_ext = 0; m_lp = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!por_n) mreset();
    else mstep();
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit inr;
    int exp_dom, exp_rd;
    inr = (m_ph == 1) || (m_ph == 2);
    exp_dom = 0;
    for (int i = 0; i < NDOM; i++)
      if (inr && (i != 0 || !m_lp)) exp_dom = exp_dom | (1 << i);
    case (rd_addr)
      2'd0: exp_rd = int'(m_fes);
      2'd1: exp_rd = int'(m_dis);
      2'd2: exp_rd = int'(m_ss);
      default: exp_rd = int'(m_pin);
    endcase
    chk("R5 phase", int'(phase), m_ph);
    chk("R11 dom_rst", int'(dom_rst), exp_dom);
    chk("R9 flash_rst", int'(flash_rst), int'(inr || m_foff));
    chk("R7 ext_rst_out", int'(ext_rst_out), int'(m_ext && !m_stby));
    chk("R1 rd_data", int'(rd_data), exp_rd);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [NEV-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic run_idle();
    int n;
    n = 0;
    flash_done = 1;
    while (phase != 2'd0 && n < 200) begin tick(); n++; end
    flash_done = 0;
    chk("R5 reached idle", int'(phase), 0);
  endtask

  initial begin
    mreset();
    repeat (3) tick();
    chk("R10 phase in reset", int'(phase), 1);
    chk("R10 domains in reset", int'(dom_rst), 7);
    chk("R10 flash/pin in reset", int'({flash_rst, ext_rst_out}), 3);
    por_n = 1;
    repeat (MIN - 1) tick();
    chk("R5 Phase1 length", int'(phase), 1);
    tick();
    chk("R5 Phase2 entered", int'(phase), 2);
    flash_done = 1; tick();
    chk("R5 Phase3 on done", int'(phase), 3);
    tick();
    flash_done = 0;
    chk("R7 pin released at end", int'(ext_rst_out), 0);
    chk("R11 domains idle", int'(dom_rst), 0);

    wr(2'd1, 4'b0010);
    wr(2'd1, 4'b1111);
    rd_addr = 2'd1; tick();
    chk("R2 write-once", int'(rd_data), 2);

    rd_addr = 2'd0;
    fevt = 4'b0010; tick(); fevt = '0; tick();
    chk("R3 disabled event phase", int'(phase), 0);
    chk("R3 disabled event flag", int'(rd_data), 0);

    fevt = 4'b0101; tick(); fevt = '0;
    chk("R4 event to Phase1", int'(phase), 1);
    chk("R1 two flags", int'(rd_data), 5);
    wr(2'd0, 4'b0001);
    chk("R1 write-one clear", int'(rd_data), 4);
    run_idle();

    wr(2'd2, 4'b0100);
    fevt = 4'b0100; tick(); fevt = '0;
    chk("R6 short to Phase3", int'(phase), 3);
    chk("R6 no domain/flash reset", int'({dom_rst, flash_rst}), 0);
    run_idle();

    wr(2'd3, 4'b1000);
    fevt = 4'b1000; tick(); fevt = '0;
    chk("R7 pin driven", int'(ext_rst_out), 1);
    repeat (MIN) tick();
    chk("R7 pin in Phase2", int'({phase, ext_rst_out}), 5);
    flash_done = 1; tick();
    chk("R7 pin in Phase3", int'({phase, ext_rst_out}), 7);
    tick(); flash_done = 0;
    chk("R7 pin after Phase3", int'(ext_rst_out), 0);

    stby_enter = 1; tick(); stby_enter = 0;
    chk("R8 standby phase", int'(phase), 1);
    chk("R8 domain pattern", int'(dom_rst), 6);
    chk("R8 pin free", int'(ext_rst_out), 0);
    repeat (30) tick();
    chk("R8 counter frozen", int'(phase), 1);
    stby_exit = 1; tick(); stby_exit = 0;
    repeat (MIN - 1) tick();
    chk("R8 Phase1 after exit", int'(phase), 1);
    tick();
    chk("R8 Phase2 after exit", int'(phase), 2);
    run_idle();

    flash_keep_off = 1; stby_enter = 1; tick(); stby_enter = 0; flash_keep_off = 0;
    stby_exit = 1; tick(); stby_exit = 0;
    repeat (MIN) tick();
    chk("R9 Phase2", int'(phase), 2);
    tick();
    chk("R9 no flash wait P2", int'(phase), 3);
    tick();
    chk("R9 no flash wait P3", int'(phase), 0);
    chk("R9 flash held", int'(flash_rst), 1);
    ext_req = 1; tick(); ext_req = 0;
    chk("R4 external to Phase1", int'(phase), 1);
    run_idle();
    chk("R9 flash released", int'(flash_rst), 0);

    por_n = 0; tick();
    chk("R10 second reset", int'({phase, flash_rst, ext_rst_out}), 7);
    por_n = 1;
    wr(2'd1, 4'b0001);
    rd_addr = 2'd1; tick();
    chk("R10 lock cleared", int'(rd_data), 1);
    rd_addr = 2'd2; tick();
    chk("R10 short cfg cleared", int'(rd_data), 0);
    run_idle();

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule